// File: doc/BRIEF.md
# In-Order Dispatch Stage with Stall Accounting

This block sits between a decoded micro-operation queue and the out-of-order back end. Each cycle it looks at up to `MAXW` candidate instructions, oldest in slot 0. It grants the longest prefix of them that fits inside the dispatch width and inside the credits that neighbouring units advertise. Those credits are free reorder-buffer entries, free rename registers, scheduler space, load-queue space and store-queue space. Grants are combinational, so the queue can pop the granted instructions in the same cycle.

When an instruction cannot go, the block charges the cycle to exactly one cause counter, chosen by a fixed priority. The block also keeps a histogram of how many instructions were dispatched in each cycle. Credits used by older slots of a group are subtracted before younger slots are tested. A whole group can therefore never over-commit a resource.

Top module: `dispatch_stage`

## Requirements
- R1: Grants form a prefix from slot 0. Slot 0 holds the oldest instruction. A slot that is invalid, or that fails any check, ends the group, and no younger slot is granted in that cycle.
- R2: At most W slots are granted. W equals `cfgWidth` when `cfgWidth` is between 1 and `MAXW`. W equals `MAXW` when `cfgWidth` is 0 or larger than `MAXW`.
- R3: The sum of `inUops` over granted slots never exceeds `robCredit`.
- R4: The sum of `inDests` over granted slots never exceeds the register pool. The pool is the smaller of `regCredit` and `cfgRegLimit`. When `cfgRegLimit` is 0 the pool is unbounded and `regCredit` is ignored.
- R5: Each granted slot takes one scheduler entry. The number granted never exceeds `schedCredit`.
- R6: Granted slots with `inLoad` set never exceed `lqCredit`. Granted slots with `inStore` set never exceed `sqCredit`.
- R7: A slot with `inSolo` set is granted only in slot 0. When slot 0 has `inSolo` set, it is granted alone.
- R8: A cycle whose group is ended by a failing valid slot inside the width increments exactly one stall counter. The cause is the first failing check in this order: rob (counter 0), registers (1), scheduler (2), load queue (3), store queue (4), solo restriction (5). Counter k sits at `stallCnt[k*CW +: CW]`.
- R9: A cycle whose group ends only because of the width limit or an invalid slot charges no stall counter.
- R10: Every cycle out of reset increments histogram bin N, where N is the number of grants in that cycle. Bin N sits at `histCnt[N*CW +: CW]`. `grantCount` equals the number of grants.
- R11: Reset clears all stall counters and histogram bins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset of the counters |
| cfgWidth | input | WW | dispatch width; 0 selects MAXW |
| cfgRegLimit | input | CRW | rename register cap; 0 means unbounded |
| inValid | input | MAXW | slot holds an instruction (slot 0 is oldest) |
| inUops | input | MAXW*UW | micro-op count per slot (reorder-buffer entries needed) |
| inDests | input | MAXW*DW | destination registers to rename per slot |
| inLoad | input | MAXW | slot needs a load-queue entry |
| inStore | input | MAXW | slot needs a store-queue entry |
| inSolo | input | MAXW | slot must be dispatched alone in slot 0 |
| robCredit | input | CRW | free reorder-buffer entries |
| regCredit | input | CRW | free rename registers |
| schedCredit | input | CRW | free scheduler entries |
| lqCredit | input | CRW | free load-queue entries |
| sqCredit | input | CRW | free store-queue entries |
| grant | output | MAXW | per-slot dispatch grant |
| grantCount | output | CGW | number of slots granted this cycle |
| stallCnt | output | 6*CW | stall counters per cause |
| histCnt | output | (MAXW+1)*CW | dispatch-count histogram bins |

## Verification
The hardest case to reach is a group stopped in a younger slot by one resource while an even younger slot would still fit. The failing slot often trips several checks at once, and the priority decides which counter moves. Random credits rarely produce that exact combination. Directed cycles therefore build it with deliberately tight credits: a large micro-op count in slot 1 that also exceeds the register cap, and solo flags in slots 0, 1 and 2. A long pseudo-random sweep adds zero credits, zero and over-range widths, gaps in `inValid` and a zero register cap. Every cycle, the cause counters and histogram are compared against totals computed arithmetically.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  localparam int NCAUSE = 6;

  typedef enum logic [2:0] {
    CAUSE_ROB   = 3'd0,
    CAUSE_REG   = 3'd1,
    CAUSE_SCHED = 3'd2,
    CAUSE_LDQ   = 3'd3,
    CAUSE_STQ   = 3'd4,
    CAUSE_SOLO  = 3'd5,
    CAUSE_NONE  = 3'd7
  } causeE;

  // strobes from control to the counter datapath
  typedef struct packed {
    logic [NCAUSE-1:0] stallInc;
    logic [4:0]        binSel;
  } dispStrobeT;
endpackage

// File: rtl/dsp_ctrl.sv
module dsp_ctrl
  import dsp_pkg::*;
#(
  parameter int MAXW = 4,
  parameter int UW   = 2,
  parameter int DW   = 2,
  parameter int CRW  = 5,
  parameter int WW   = 3,
  localparam int CGW = $clog2(MAXW + 1)
) (
  input  logic [WW-1:0]       cfgWidth,
  input  logic [CRW-1:0]      cfgRegLimit,
  input  logic [MAXW-1:0]     inValid,
  input  logic [MAXW*UW-1:0]  inUops,
  input  logic [MAXW*DW-1:0]  inDests,
  input  logic [MAXW-1:0]     inLoad,
  input  logic [MAXW-1:0]     inStore,
  input  logic [MAXW-1:0]     inSolo,
  input  logic [CRW-1:0]      robCredit,
  input  logic [CRW-1:0]      regCredit,
  input  logic [CRW-1:0]      schedCredit,
  input  logic [CRW-1:0]      lqCredit,
  input  logic [CRW-1:0]      sqCredit,
  output logic [MAXW-1:0]     grant,
  output logic [CGW-1:0]      grantCount,
  output dispStrobeT          strobe
);
  localparam int MW = (CRW > UW) ? ((CRW > DW) ? CRW : DW) : ((UW > DW) ? UW : DW);
  localparam int AW = MW + $clog2(MAXW + 1) + 1;

  int          effW;
  int          nGrant;
  logic        alive;
  logic        regUnbounded;
  causeE       stopCause;
  causeE       slotCause;
  logic [AW-1:0] regCap;
  logic [AW-1:0] robUse, regUse, schedUse, ldUse, stUse;
  logic [AW-1:0] robNext, regNext;

  always_comb begin
    effW = (cfgWidth == '0 || int'(cfgWidth) > MAXW) ? MAXW : int'(cfgWidth);
    regUnbounded = (cfgRegLimit == '0);
    regCap = (cfgRegLimit < regCredit) ? AW'(cfgRegLimit) : AW'(regCredit);
    robUse = '0; regUse = '0; schedUse = '0; ldUse = '0; stUse = '0;
    robNext = '0; regNext = '0;
    alive = 1'b1;
    nGrant = 0;
    grant = '0;
    stopCause = CAUSE_NONE;
    slotCause = CAUSE_NONE;
    for (int i = 0; i < MAXW; i++) begin
      if (alive) begin
        if (!inValid[i] || i >= effW) begin
          alive = 1'b0;
        end else begin
          robNext = robUse + AW'(inUops[i*UW +: UW]);
          regNext = regUse + AW'(inDests[i*DW +: DW]);
          if (robNext > AW'(robCredit))                         slotCause = CAUSE_ROB;
          else if (!regUnbounded && regNext > regCap)           slotCause = CAUSE_REG;
          else if (schedUse + 1'b1 > AW'(schedCredit))          slotCause = CAUSE_SCHED;
          else if (inLoad[i] && ldUse + 1'b1 > AW'(lqCredit))   slotCause = CAUSE_LDQ;
          else if (inStore[i] && stUse + 1'b1 > AW'(sqCredit))  slotCause = CAUSE_STQ;
          else if (i != 0 && (inSolo[i] || inSolo[0]))          slotCause = CAUSE_SOLO;
          else                                                  slotCause = CAUSE_NONE;
          if (slotCause != CAUSE_NONE) begin
            alive = 1'b0;
            stopCause = slotCause;
          end else begin
            grant[i] = 1'b1;
            nGrant = nGrant + 1;
            robUse = robNext;
            regUse = regNext;
            schedUse = schedUse + 1'b1;
            if (inLoad[i])  ldUse = ldUse + 1'b1;
            if (inStore[i]) stUse = stUse + 1'b1;
          end
        end
      end
    end
    grantCount = CGW'(nGrant);
    strobe.binSel = 5'(nGrant);
    for (int k = 0; k < NCAUSE; k++) begin
      strobe.stallInc[k] = (stopCause == causeE'(k));
    end
  end
endmodule

// File: rtl/dsp_counters.sv
module dsp_counters
  import dsp_pkg::*;
#(
  parameter int MAXW = 4,
  parameter int CW   = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dispStrobeT              strobe,
  output logic [NCAUSE*CW-1:0]    stallCnt,
  output logic [(MAXW+1)*CW-1:0]  histCnt
);
  localparam int NBIN = MAXW + 1;

  logic [CW-1:0] stallReg [NCAUSE];
  logic [CW-1:0] histReg  [NBIN];
  logic [CW-1:0] histPrev [NBIN];
  logic [CW-1:0] stallPrev [NCAUSE];
  logic [NBIN-1:0]   binMoved;
  logic [NCAUSE-1:0] causeMoved;
  logic pastOk;

  for (genvar g = 0; g < NCAUSE; g++) begin : g_stall
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stallReg[g] <= '0;
        stallPrev[g] <= '0;
      end else begin
        stallPrev[g] <= stallReg[g];
        if (strobe.stallInc[g]) stallReg[g] <= stallReg[g] + 1'b1;
      end
    end
    assign stallCnt[g*CW +: CW] = stallReg[g];
    assign causeMoved[g] = (stallReg[g] != stallPrev[g]);
  end

  for (genvar b = 0; b < NBIN; b++) begin : g_hist
    always_ff @(posedge clk) begin
      if (!rstN) begin
        histReg[b] <= '0;
        histPrev[b] <= '0;
      end else begin
        histPrev[b] <= histReg[b];
        if (strobe.binSel == 5'(b)) histReg[b] <= histReg[b] + 1'b1;
      end
    end
    assign histCnt[b*CW +: CW] = histReg[b];
    assign binMoved[b] = (histReg[b] != histPrev[b]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  // R10
  hist_one_bin_chk: assert property (@(posedge clk) disable iff (!rstN)
    pastOk |-> $onehot(binMoved));

  // R8
  stall_one_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    pastOk |-> $onehot0(causeMoved));

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (stallReg[0] == '0 && histReg[0] == '0));
endmodule

// File: rtl/dispatch_stage.sv
module dispatch_stage
  import dsp_pkg::*;
#(
  parameter int MAXW = 4,
  parameter int UW   = 2,
  parameter int DW   = 2,
  parameter int CRW  = 5,
  parameter int WW   = 3,
  parameter int CW   = 16,
  localparam int CGW = $clog2(MAXW + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [WW-1:0]           cfgWidth,
  input  logic [CRW-1:0]          cfgRegLimit,
  input  logic [MAXW-1:0]         inValid,
  input  logic [MAXW*UW-1:0]      inUops,
  input  logic [MAXW*DW-1:0]      inDests,
  input  logic [MAXW-1:0]         inLoad,
  input  logic [MAXW-1:0]         inStore,
  input  logic [MAXW-1:0]         inSolo,
  input  logic [CRW-1:0]          robCredit,
  input  logic [CRW-1:0]          regCredit,
  input  logic [CRW-1:0]          schedCredit,
  input  logic [CRW-1:0]          lqCredit,
  input  logic [CRW-1:0]          sqCredit,
  output logic [MAXW-1:0]         grant,
  output logic [CGW-1:0]          grantCount,
  output logic [6*CW-1:0]         stallCnt,
  output logic [(MAXW+1)*CW-1:0]  histCnt
);
  dispStrobeT strobe;

  dsp_ctrl #(.MAXW(MAXW), .UW(UW), .DW(DW), .CRW(CRW), .WW(WW)) ctrl_i (
    .cfgWidth(cfgWidth), .cfgRegLimit(cfgRegLimit), .inValid(inValid),
    .inUops(inUops), .inDests(inDests), .inLoad(inLoad), .inStore(inStore),
    .inSolo(inSolo), .robCredit(robCredit), .regCredit(regCredit),
    .schedCredit(schedCredit), .lqCredit(lqCredit), .sqCredit(sqCredit),
    .grant(grant), .grantCount(grantCount), .strobe(strobe)
  );

  dsp_counters #(.MAXW(MAXW), .CW(CW)) counters_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .stallCnt(stallCnt), .histCnt(histCnt)
  );

  // granted micro-op total, for the reorder-buffer bound check
  int robTaken;
  always_comb begin
    robTaken = 0;
    for (int i = 0; i < MAXW; i++)
      if (grant[i]) robTaken = robTaken + int'(inUops[i*UW +: UW]);
  end

  // R1
  grant_prefix_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({1'b0, grant} + (MAXW+1)'(1)));

  // R2
  width_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWidth != '0 && int'(cfgWidth) <= MAXW) |-> ($countones(grant) <= int'(cfgWidth)));

  // R3
  rob_credit_chk: assert property (@(posedge clk) disable iff (!rstN)
    robTaken <= int'(robCredit));

  // R7
  solo_alone_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(grant & inSolo)) |-> (grant == MAXW'(1)));

  // R9
  no_stall_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grant == inValid) |-> (strobe.stallInc == '0));

  // R10
  count_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(grantCount) == $countones(grant));
endmodule

// File: tb/dispatch_stage_tb_top.sv
`timescale 1ns/1ps
module dispatch_stage_tb_top;
  localparam int MAXW = 3;
  localparam int UW = 2;
  localparam int DW = 2;
  localparam int CRW = 4;
  localparam int WW = 3;
  localparam int CW = 16;
  localparam int CGW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [WW-1:0] cfgWidth;
  logic [CRW-1:0] cfgRegLimit, robCredit, regCredit, schedCredit, lqCredit, sqCredit;
  logic [MAXW-1:0] inValid, inLoad, inStore, inSolo;
  logic [MAXW*UW-1:0] inUops;
  logic [MAXW*DW-1:0] inDests;
  logic [MAXW-1:0] grant;
  logic [CGW-1:0] grantCount;
  logic [6*CW-1:0] stallCnt;
  logic [(MAXW+1)*CW-1:0] histCnt;

  int total = 0;
  int bad = 0;
  int expStall [6];
  int expHist [MAXW+1];
  int mGrant, mCause, mCount;
  logic [31:0] rs = 32'h1234_5678;

  always #2.5 clk = ~clk;

  dispatch_stage #(.MAXW(MAXW), .UW(UW), .DW(DW), .CRW(CRW), .WW(WW), .CW(CW)) dut_i (
    .clk(clk), .rstN(rstN), .cfgWidth(cfgWidth), .cfgRegLimit(cfgRegLimit),
    .inValid(inValid), .inUops(inUops), .inDests(inDests), .inLoad(inLoad),
    .inStore(inStore), .inSolo(inSolo), .robCredit(robCredit), .regCredit(regCredit),
    .schedCredit(schedCredit), .lqCredit(lqCredit), .sqCredit(sqCredit),
    .grant(grant), .grantCount(grantCount), .stallCnt(stallCnt), .histCnt(histCnt)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic defaults();
    cfgWidth = '0; cfgRegLimit = '0;
    robCredit = 4'd15; regCredit = 4'd15; schedCredit = 4'd15;
    lqCredit = 4'd15; sqCredit = 4'd15;
    inValid = '1; inLoad = '0; inStore = '0; inSolo = '0;
    inUops = {2'd1, 2'd1, 2'd1};
    inDests = {2'd1, 2'd1, 2'd1};
  endtask

  // arithmetic reference derived from the requirements
  task automatic model();
    int effW, cap, ru, gu, su, lu, tu, c, u, d;
    bit alive;
    effW = (cfgWidth == 0 || int'(cfgWidth) > MAXW) ? MAXW : int'(cfgWidth);
    cap = (cfgRegLimit < regCredit) ? int'(cfgRegLimit) : int'(regCredit);
    ru = 0; gu = 0; su = 0; lu = 0; tu = 0;
    alive = 1; mGrant = 0; mCause = -1; mCount = 0;
    for (int i = 0; i < MAXW; i++) begin
      if (alive) begin
        if (!inValid[i] || i >= effW) alive = 0;
        else begin
          u = int'(inUops[i*UW +: UW]);
          d = int'(inDests[i*DW +: DW]);
          c = -1;
          if (ru + u > int'(robCredit)) c = 0;
          else if (cfgRegLimit != 0 && gu + d > cap) c = 1;
          else if (su + 1 > int'(schedCredit)) c = 2;
          else if (inLoad[i] && lu + 1 > int'(lqCredit)) c = 3;
          else if (inStore[i] && tu + 1 > int'(sqCredit)) c = 4;
          else if (i > 0 && (inSolo[i] || inSolo[0])) c = 5;
          if (c >= 0) begin
            alive = 0; mCause = c;
          end else begin
            mGrant |= (1 << i); mCount++;
            ru += u; gu += d; su++;
            if (inLoad[i]) lu++;
            if (inStore[i]) tu++;
          end
        end
      end
    end
  endtask

  task automatic checkCounters();
    for (int c = 0; c < 6; c++)
      check("R8", $sformatf("stall counter %0d", c), int'(stallCnt[c*CW +: CW]), expStall[c]);
    for (int b = 0; b <= MAXW; b++)
      check("R10", $sformatf("histogram bin %0d", b), int'(histCnt[b*CW +: CW]), expHist[b]);
  endtask

  // called right after a negedge with the new inputs applied
  task automatic runCycle(input string req, input int expGrant);
    checkCounters();
    #1;
    model();
    check("R1 R2 R3 R4 R5 R6 R7", "grant vs model", int'(grant), mGrant);
    check("R10", "grantCount", int'(grantCount), mCount);
    if (expGrant >= 0) check(req, "directed grant", int'(grant), expGrant);
    if (mCause >= 0) expStall[mCause]++;
    expHist[mCount]++;
  endtask

  function automatic logic [31:0] nextRand(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  initial begin
    #(5.0 * 190000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 6; c++) expStall[c] = 0;
    for (int b = 0; b <= MAXW; b++) expHist[b] = 0;
    defaults();
    repeat (3) @(negedge clk);
    // R11 reset state
    for (int c = 0; c < 6; c++) check("R11", "stall after reset", int'(stallCnt[c*CW +: CW]), 0);
    for (int b = 0; b <= MAXW; b++) check("R11", "hist after reset", int'(histCnt[b*CW +: CW]), 0);

    @(negedge clk); rstN = 1'b1; defaults(); runCycle("R2", 7);
    @(negedge clk); defaults(); cfgWidth = 3'd2; runCycle("R2", 3);
    @(negedge clk); defaults(); cfgWidth = 3'd5; runCycle("R2", 7);
    @(negedge clk); defaults(); cfgWidth = 3'd1; runCycle("R9", 1);
    @(negedge clk); defaults(); inUops = {2'd2, 2'd2, 2'd2}; robCredit = 4'd5; runCycle("R3", 3);
    @(negedge clk); defaults(); inDests = {2'd1, 2'd2, 2'd1}; regCredit = 4'd2; runCycle("R4", 7);
    @(negedge clk); defaults(); inDests = {2'd1, 2'd2, 2'd1}; cfgRegLimit = 4'd2; runCycle("R4", 1);
    @(negedge clk); defaults(); inDests = {2'd1, 2'd2, 2'd1}; cfgRegLimit = 4'd15; regCredit = 4'd3; runCycle("R4", 3);
    @(negedge clk); defaults(); schedCredit = 4'd1; runCycle("R5", 1);
    @(negedge clk); defaults(); schedCredit = 4'd0; runCycle("R5", 0);
    @(negedge clk); defaults(); inLoad = 3'b011; lqCredit = 4'd1; runCycle("R6", 1);
    @(negedge clk); defaults(); inStore = 3'b110; sqCredit = 4'd1; runCycle("R6", 3);
    @(negedge clk); defaults(); inSolo = 3'b010; runCycle("R7", 1);
    @(negedge clk); defaults(); inSolo = 3'b001; runCycle("R7", 1);
    @(negedge clk); defaults(); inSolo = 3'b100; runCycle("R7", 3);
    @(negedge clk); defaults(); inValid = 3'b101; runCycle("R1", 1);
    @(negedge clk); defaults(); inUops = {2'd1, 2'd3, 2'd1}; robCredit = 4'd3; runCycle("R1", 1);
    @(negedge clk); defaults(); inUops = {2'd1, 2'd3, 2'd1}; inDests = {2'd1, 2'd3, 2'd1};
                    robCredit = 4'd3; cfgRegLimit = 4'd3; runCycle("R8", 1);
    @(negedge clk); defaults(); inValid = 3'b000; runCycle("R9", 0);

    // near-exhaustive pseudo-random sweep
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      rs = nextRand(rs); inValid = rs[2:0] | ((rs[3]) ? 3'b000 : 3'b001);
      inUops = rs[9:4]; inDests = rs[15:10];
      inLoad = rs[18:16]; inStore = rs[21:19];
      inSolo = (rs[24:22] == 3'b000) ? rs[27:25] : 3'b000;
      cfgWidth = rs[30:28];
      rs = nextRand(rs);
      robCredit = {1'b0, rs[2:0]};
      cfgRegLimit = rs[3] ? 4'd0 : rs[7:4];
      regCredit = {1'b0, rs[10:8]};
      schedCredit = {2'b00, rs[12:11]};
      lqCredit = {3'b000, rs[13]};
      sqCredit = {3'b000, rs[14]};
      runCycle("R8", -1);
    end

    @(negedge clk); defaults(); inValid = '0;
    checkCounters();
    // R11 reset in mid-run clears everything
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    for (int c = 0; c < 6; c++) check("R11", "stall after late reset", int'(stallCnt[c*CW +: CW]), 0);
    for (int b = 0; b <= MAXW; b++) check("R11", "hist after late reset", int'(histCnt[b*CW +: CW]), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule